// File: doc/BRIEF.md
# Snoop response controller

This block sits beside a look-aside second-level cache and answers bus transactions that other masters start. When a transfer start arrives while the controller is idle, it drives the line address of that transfer to the tag store. The hit and dirty flags come back one cycle later. From them the controller chooses a coherency response and any line-state change.

For a clean line, no retry is issued. A write snoop invalidates the clean line and a read snoop leaves it as it is. A miss changes nothing, so a write snoop that misses never allocates a line. A dirty hit raises the address retry together with a "write-back pending" flag, and both stay up until one cycle after the address acknowledge. The controller then asks for the bus and pushes the dirty line out once it is granted. The processor's own cache may signal a newer dirty copy during the retry window. In that case the controller drops its request, disregards grants, waits for the processor's write-back, and then either refreshes or invalidates its copy.

Only one snoop is tracked at a time. A transfer start that arrives while the controller is busy is not looked up. It is retried instead.

Top module: `snoop_resp_ctrl`

## Requirements
- R1: After reset, `snp_retry_o`, `snp_castout_o`, `breq_o` and `cmd_valid_o` are low and `cmd_op_o` is 0.
- R2: A snoop that misses, whether read or write, raises no retry and issues no command, so there is no allocation on a write miss.
- R3: A write snoop that hits a clean line issues one `cmd_valid_o` pulse with `cmd_op_o`=1 (invalidate) and the snooped line address. This happens in the cycle after the lookup cycle. A read snoop that hits a clean line issues nothing.
- R4: A dirty hit raises `snp_retry_o` and `snp_castout_o` from the cycle after the lookup cycle until one cycle after the cycle in which `aack_i` is high, and both are low the cycle after that. No command is issued in that interval.
- R5: `breq_o` rises together with the retry on a dirty hit and stays high after the window. The first `bg_i` after the window produces a command in the next cycle, with `cmd_op_o`=3 (push and keep clean) for a read snoop or 4 (push and invalidate) for a write snoop. `breq_o` drops in that same cycle.
- R6: If `cpu_retry_i` is high during the retry window, `breq_o` is low from the next cycle and grants have no effect. After the window, a `cpu_wb_i` pulse produces a command in the next cycle, with `cmd_op_o`=2 (refresh from the processor's data) for a read snoop or 1 (invalidate) for a write snoop.
- R7: A transfer start that arrives while the controller is busy does not assert `lk_req_o`. It raises `snp_retry_o`, but not `snp_castout_o`, from the next cycle until one cycle after its `aack_i`.
- R8: A transfer start that arrives while the controller is idle asserts `lk_req_o` in the same cycle, with `lk_line_o` equal to `ts_addr_i` shifted right by `LINE_OFS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_i | input | 1 | Transfer start by another master |
| ts_wr_i | input | 1 | Transfer is a write (1) or a read (0) |
| ts_addr_i | input | ADDR_W | Transfer address |
| aack_i | input | 1 | Address acknowledge |
| lk_req_o | output | 1 | Tag lookup request |
| lk_line_o | output | ADDR_W-LINE_OFS | Line address to look up |
| lk_hit_i | input | 1 | Lookup hit, valid the cycle after the request |
| lk_dirty_i | input | 1 | Hit line is dirty, valid with `lk_hit_i` |
| cpu_retry_i | input | 1 | Sampled retry from the processor's cache |
| cpu_wb_i | input | 1 | Processor write-back of the line observed |
| bg_i | input | 1 | Bus grant |
| snp_retry_o | output | 1 | Address retry |
| snp_castout_o | output | 1 | Snooped dirty data will be written back |
| breq_o | output | 1 | Bus request |
| cmd_valid_o | output | 1 | Line-state command strobe |
| cmd_op_o | output | 3 | Command: 1 invalidate, 2 refresh, 3 push keep, 4 push drop |
| cmd_line_o | output | ADDR_W-LINE_OFS | Line address of the command |

## Verification
The lookup request and the line address are combinational, so they are checked in the same cycle as the transfer start. Every other result is registered. Commands from a lookup, and the first retry cycle, appear two cycles after the transfer-start cycle. Retry falls two cycles after the acknowledge cycle. Commands that follow a grant or a processor write-back appear one cycle after that input. The bench drives inputs and samples outputs at falling edges, and each check is placed at exactly the falling edge of the cycle counted this way.

// File: rtl/snp_pkg.sv
package snp_pkg;
   typedef enum logic [2:0] {
      OP_NONE      = 3'd0,
      OP_INVAL     = 3'd1,
      OP_REFRESH   = 3'd2,
      OP_PUSH_KEEP = 3'd3,
      OP_PUSH_DROP = 3'd4
   } line_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_HOLD,
      ST_REQ,
      ST_YIELD
   } snp_st_e;

   localparam int unsigned N_WIN = 2;
   localparam int unsigned WIN_SNOOP = 0;
   localparam int unsigned WIN_BUSY  = 1;
endpackage

// File: rtl/snp_window.sv
// Holds a response flag from a start pulse until one cycle past the address acknowledge.
module snp_window (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic aack_i,
   output logic active_o,
   output logic last_o
);
   logic act_q, fin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         fin_q <= 1'b0;
      end else if (start_i) begin
         act_q <= 1'b1;
         fin_q <= aack_i;
      end else if (fin_q) begin
         act_q <= 1'b0;
         fin_q <= 1'b0;
      end else if (act_q && aack_i) begin
         fin_q <= 1'b1;
      end
   end

   assign active_o = act_q;
   assign last_o   = fin_q;
endmodule

// File: rtl/snp_fsm.sv
// Sequencer for one outstanding snoop: lookup, hold, push or yield, line command.
module snp_fsm
   import snp_pkg::*;
#(
   parameter int unsigned LA_W = 27
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ts_i,
   input  logic            ts_wr_i,
   input  logic [LA_W-1:0] ts_line_i,
   input  logic            hit_i,
   input  logic            dirty_i,
   input  logic            cpu_retry_i,
   input  logic            cpu_wb_i,
   input  logic            bg_i,
   input  logic            win_active_i,
   input  logic            win_last_i,
   output logic            busy_o,
   output logic            dirty_hit_o,
   output logic            breq_o,
   output logic            cmd_valid_o,
   output line_op_e        cmd_op_o,
   output logic [LA_W-1:0] cmd_line_o
);
   snp_st_e         st_q, st_n;
   line_op_e        op_n;
   logic            wr_q, yield_q;
   logic [LA_W-1:0] line_q;

   assign busy_o      = (st_q != ST_IDLE);
   assign dirty_hit_o = (st_q == ST_LOOK) && hit_i && dirty_i;
   assign breq_o      = ((st_q == ST_HOLD) && !yield_q) || (st_q == ST_REQ);

   always_comb begin
      st_n = st_q;
      op_n = OP_NONE;
      unique case (st_q)
         ST_IDLE:  if (ts_i) st_n = ST_LOOK;
         ST_LOOK: begin
            if (dirty_hit_o) st_n = ST_HOLD;
            else begin
               st_n = ST_IDLE;
               if (hit_i && wr_q) op_n = OP_INVAL;
            end
         end
         ST_HOLD:  if (win_last_i) st_n = (yield_q || cpu_retry_i) ? ST_YIELD : ST_REQ;
         ST_REQ: begin
            if (bg_i) begin
               st_n = ST_IDLE;
               op_n = wr_q ? OP_PUSH_DROP : OP_PUSH_KEEP;
            end
         end
         ST_YIELD: begin
            if (cpu_wb_i) begin
               st_n = ST_IDLE;
               op_n = wr_q ? OP_INVAL : OP_REFRESH;
            end
         end
         default:  st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         wr_q        <= 1'b0;
         yield_q     <= 1'b0;
         line_q      <= '0;
         cmd_valid_o <= 1'b0;
         cmd_op_o    <= OP_NONE;
         cmd_line_o  <= '0;
      end else begin
         st_q <= st_n;
         if (st_q == ST_IDLE && ts_i) begin
            wr_q   <= ts_wr_i;
            line_q <= ts_line_i;
         end
         if (st_q == ST_LOOK) yield_q <= 1'b0;
         else if (st_q == ST_HOLD && win_active_i && cpu_retry_i) yield_q <= 1'b1;
         cmd_valid_o <= (op_n != OP_NONE);
         cmd_op_o    <= op_n;
         if (op_n != OP_NONE) cmd_line_o <= line_q;
      end
   end
endmodule

// File: rtl/snoop_resp_ctrl.sv
module snoop_resp_ctrl
   import snp_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned LINE_OFS    = 5,
   parameter bit          TRACK_DIRTY = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ts_i,
   input  logic                       ts_wr_i,
   input  logic [ADDR_W-1:0]          ts_addr_i,
   input  logic                       aack_i,
   output logic                       lk_req_o,
   output logic [ADDR_W-LINE_OFS-1:0] lk_line_o,
   input  logic                       lk_hit_i,
   input  logic                       lk_dirty_i,
   input  logic                       cpu_retry_i,
   input  logic                       cpu_wb_i,
   input  logic                       bg_i,
   output logic                       snp_retry_o,
   output logic                       snp_castout_o,
   output logic                       breq_o,
   output logic                       cmd_valid_o,
   output logic [2:0]                 cmd_op_o,
   output logic [ADDR_W-LINE_OFS-1:0] cmd_line_o
);
   localparam int unsigned LA_W = ADDR_W - LINE_OFS;

   initial begin
      if (LINE_OFS >= ADDR_W) $fatal(1, "LINE_OFS must be below ADDR_W");
      if (LINE_OFS < 2)       $fatal(1, "LINE_OFS must cover at least one beat");
   end

   logic             busy, dirty_hit, dirty_eff;
   logic [N_WIN-1:0] win_start, win_act, win_last;
   line_op_e         op;

   generate
      if (TRACK_DIRTY) begin : g_dirty
         assign dirty_eff = lk_dirty_i;
      end else begin : g_wt_only
         logic unused_dirty;
         assign unused_dirty = lk_dirty_i;
         assign dirty_eff    = 1'b0;
      end
   endgenerate

   assign lk_req_o  = ts_i && !busy;
   assign lk_line_o = ts_addr_i[ADDR_W-1:LINE_OFS];

   assign win_start[WIN_SNOOP] = dirty_hit;
   assign win_start[WIN_BUSY]  = ts_i && busy && !win_act[WIN_BUSY];

   generate
      for (genvar w = 0; w < N_WIN; w++) begin : g_win
         snp_window i_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (win_start[w]),
            .aack_i   (aack_i),
            .active_o (win_act[w]),
            .last_o   (win_last[w])
         );
      end
   endgenerate

   snp_fsm #(.LA_W(LA_W)) i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .ts_i         (ts_i),
      .ts_wr_i      (ts_wr_i),
      .ts_line_i    (lk_line_o),
      .hit_i        (lk_hit_i),
      .dirty_i      (dirty_eff),
      .cpu_retry_i  (cpu_retry_i),
      .cpu_wb_i     (cpu_wb_i),
      .bg_i         (bg_i),
      .win_active_i (win_act[WIN_SNOOP]),
      .win_last_i   (win_last[WIN_SNOOP]),
      .busy_o       (busy),
      .dirty_hit_o  (dirty_hit),
      .breq_o       (breq_o),
      .cmd_valid_o  (cmd_valid_o),
      .cmd_op_o     (op),
      .cmd_line_o   (cmd_line_o)
   );

   assign cmd_op_o      = op;
   assign snp_retry_o   = |win_act;
   assign snp_castout_o = win_act[WIN_SNOOP];
endmodule

// File: rtl/snp_resp_chk.sv
module snp_resp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       lk_req_o,
   input logic       cpu_retry_i,
   input logic       snp_retry_o,
   input logic       snp_castout_o,
   input logic       breq_o,
   input logic       cmd_valid_o,
   input logic [2:0] cmd_op_o
);
   AST_CAST_NEEDS_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
      snp_castout_o |-> snp_retry_o); // R4
   AST_NO_CMD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      snp_castout_o |-> !cmd_valid_o); // R4
   AST_REQ_WITH_CAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snp_castout_o) |-> breq_o); // R5
   AST_YIELD_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_castout_o && cpu_retry_i) |=> !breq_o); // R6
   AST_LOOKUP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req_o |-> (!breq_o && !snp_castout_o)); // R7
   AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |=> !cmd_valid_o); // R3
   AST_CMD_OP_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> (cmd_op_o != 3'd0 && cmd_op_o <= 3'd4)); // R3
endmodule

bind snoop_resp_ctrl snp_resp_chk i_snp_resp_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lk_req_o      (lk_req_o),
   .cpu_retry_i   (cpu_retry_i),
   .snp_retry_o   (snp_retry_o),
   .snp_castout_o (snp_castout_o),
   .breq_o        (breq_o),
   .cmd_valid_o   (cmd_valid_o),
   .cmd_op_o      (cmd_op_o)
);

// File: tb/test_snoop_resp_ctrl.sv
module test_snoop_resp_ctrl;
   localparam int ADDR_W = 32;
   localparam int LOFS   = 5;
   localparam int LA_W   = ADDR_W - LOFS;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ts = 0, ts_wr = 0, aack = 0, hit = 0, dirty = 0;
   logic cpu_retry = 0, cpu_wb = 0, bg = 0;
   logic [ADDR_W-1:0] ts_addr = '0;
   logic lk_req, retry, castout, breq, cmd_valid;
   logic [LA_W-1:0] lk_line, cmd_line;
   logic [2:0] cmd_op;

   int checks = 0, failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   snoop_resp_ctrl #(.ADDR_W(ADDR_W), .LINE_OFS(LOFS)) i_snoop_resp_ctrl (
      .clk(clk), .rst_n(rst_n), .ts_i(ts), .ts_wr_i(ts_wr), .ts_addr_i(ts_addr),
      .aack_i(aack), .lk_req_o(lk_req), .lk_line_o(lk_line), .lk_hit_i(hit),
      .lk_dirty_i(dirty), .cpu_retry_i(cpu_retry), .cpu_wb_i(cpu_wb), .bg_i(bg),
      .snp_retry_o(retry), .snp_castout_o(castout), .breq_o(breq),
      .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_line_o(cmd_line)
   );

   // {write, hit, dirty, expected op}
   localparam logic [5:0] VEC [6] = '{
      6'b0_0_0_000, 6'b1_0_0_000, 6'b0_1_0_000,
      6'b1_1_0_001, 6'b1_0_0_000, 6'b1_1_0_001
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Ends at the falling edge of the cycle two after the transfer start.
   task automatic snoop(input logic wr, input logic h, input logic d, input logic [31:0] addr);
      @(negedge clk);
      ts = 1; ts_wr = wr; ts_addr = addr;
      #0;
      chk("R8 lk_req", 32'(lk_req), 1);
      chk("R8 lk_line", 32'(lk_line), addr >> LOFS);
      @(negedge clk);
      ts = 0; hit = h; dirty = d;
      @(negedge clk);
      hit = 0; dirty = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] a;
      repeat (3) @(negedge clk);
      chk("R1 retry", 32'(retry), 0);
      chk("R1 castout", 32'(castout), 0);
      chk("R1 breq", 32'(breq), 0);
      chk("R1 cmd_valid", 32'(cmd_valid), 0);
      chk("R1 cmd_op", 32'(cmd_op), 0);
      rst_n = 1;

      for (int k = 0; k < 6; k++) begin
         logic [5:0] v;
         string tg;
         v = VEC[k];
         tg = v[4] ? "R3" : "R2";
         a = 32'h1000_0000 + 32'(k) * 32'h0000_0460;
         snoop(v[5], v[4], v[3], a);
         chk({tg, " retry"}, 32'(retry), 0);
         chk({tg, " cmd_valid"}, 32'(cmd_valid), 32'(v[2:0] != 0));
         chk({tg, " cmd_op"}, 32'(cmd_op), 32'(v[2:0]));
         if (v[2:0] != 0) chk({tg, " cmd_line"}, 32'(cmd_line), a >> LOFS);
         @(negedge clk);
         chk({tg, " cmd pulse ends"}, 32'(cmd_valid), 0);
      end

      // Dirty read hit, pushed after grant
      a = 32'h0000_2A40;
      snoop(0, 1, 1, a);
      chk("R4 retry up", 32'(retry), 1);
      chk("R4 castout up", 32'(castout), 1);
      chk("R5 breq with retry", 32'(breq), 1);
      chk("R4 no cmd", 32'(cmd_valid), 0);
      aack = 1;
      @(negedge clk); aack = 0;
      chk("R4 retry after aack", 32'(retry), 1);
      chk("R4 castout after aack", 32'(castout), 1);
      @(negedge clk);
      chk("R4 retry dropped", 32'(retry), 0);
      chk("R5 breq held", 32'(breq), 1);
      bg = 1;
      @(negedge clk); bg = 0;
      chk("R5 cmd_valid", 32'(cmd_valid), 1);
      chk("R5 cmd_op keep", 32'(cmd_op), 3);
      chk("R5 cmd_line", 32'(cmd_line), a >> LOFS);
      chk("R5 breq dropped", 32'(breq), 0);

      // Dirty write hit, processor cache also dirty
      a = 32'h0003_1F80;
      snoop(1, 1, 1, a);
      cpu_retry = 1;
      @(negedge clk); cpu_retry = 0;
      chk("R6 breq withdrawn", 32'(breq), 0);
      chk("R6 retry held", 32'(retry), 1);
      aack = 1;
      @(negedge clk); aack = 0;
      @(negedge clk);
      bg = 1;
      @(negedge clk); bg = 0;
      chk("R6 grant ignored breq", 32'(breq), 0);
      chk("R6 grant ignored cmd", 32'(cmd_valid), 0);
      cpu_wb = 1;
      @(negedge clk); cpu_wb = 0;
      chk("R6 cmd_valid", 32'(cmd_valid), 1);
      chk("R6 cmd_op inval", 32'(cmd_op), 1);
      chk("R6 cmd_line", 32'(cmd_line), a >> LOFS);

      // Dirty read hit, then second transfer while busy
      a = 32'h0000_0CA0;
      snoop(0, 1, 1, a);
      aack = 1;
      @(negedge clk); aack = 0;
      @(negedge clk);
      ts = 1; ts_wr = 1; ts_addr = 32'h0F00_0000;
      #0;
      chk("R7 no lookup while busy", 32'(lk_req), 0);
      @(negedge clk); ts = 0;
      chk("R7 busy retry", 32'(retry), 1);
      chk("R7 no castout", 32'(castout), 0);
      aack = 1;
      @(negedge clk); aack = 0;
      chk("R7 retry after aack", 32'(retry), 1);
      @(negedge clk);
      chk("R7 retry dropped", 32'(retry), 0);
      bg = 1;
      @(negedge clk); bg = 0;
      chk("R5 cmd_op keep 2", 32'(cmd_op), 3);
      chk("R5 cmd_line 2", 32'(cmd_line), a >> LOFS);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule